// File: doc/BRIEF.md
# Dual-comparator trace trigger unit

This block sits beside a CPU bus and decides when a trace capture or a debug halt should begin. Two address comparators hold reference addresses A and B, and a data compare value qualifies accesses at address A. A three-bit mode field selects the condition that fires the trigger: one address, either address, a window between A and B, the span outside that window, B reached after A, or address A whose data matches or does not match the compare value.

Bus cycles qualify in one of two ways. With memory-access qualification every valid cycle counts, whether it is a data access or an instruction fetch. With execute qualification only fetch cycles count, and each comparator result passes through a short opcode-tracking pipeline before it is evaluated. The trigger therefore fires later, and an instruction that follows the matched one closely can slip past. The unit is one-shot. Pulsing the arm input clears its history and enables it. The first qualifying cycle then gives a one-cycle trigger pulse, sets a sticky hit flag and, if enabled, raises a halt request. After that the unit stays quiet until it is armed again.

Top module: `bus_trigger_unit`

## Requirements
- R1: After reset trigger_o, hit_o and halt_req_o are low, and the unit is disarmed: no bus cycle fires it until arm_i has been pulsed.
- R2: A cycle with arm_i high clears hit_o, halt_req_o, the A-seen history and every event still in the tracking pipeline, and arms the unit. The bus cycle presented together with arm_i is ignored.
- R3: Mode 0 fires on a qualified cycle at address A. Mode 1 fires on a qualified cycle at address A or address B, whichever comes first.
- R4: Mode 2 fires when A <= address <= B. Mode 3 fires when address < A or address > B. Both bounds are inclusive to the window.
- R5: Mode 4 fires on a qualified cycle at address B only if a qualified cycle at address A occurred in an earlier cycle since arming. A cycle that hits A and B together does not fire on its own, but it records A.
- R6: Mode 5 fires at address A when bus data equals the compare value. Mode 6 fires at address A when bus data differs from it. Mode 7 never fires.
- R7: With exec_qual_i low, any cycle with bus_valid_i high qualifies, whatever the value of bus_fetch_i. trigger_o is high in the cycle right after the qualifying bus cycle.
- R8: With exec_qual_i high, only cycles with bus_valid_i and bus_fetch_i both high qualify. trigger_o goes high TRACK_DEPTH+1 cycles after the qualifying fetch (3 with the default depth of 2).
- R9: trigger_o is a single-cycle pulse. hit_o goes high with it and stays high until the next arm. After a trigger the unit is disarmed, so later matches give no further pulse.
- R10: When halt_en_i is high at the moment of firing, halt_req_o goes high with the trigger pulse and holds until the next arm. When halt_en_i is low, halt_req_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Re-arm pulse; clears history and enables one trigger |
| mode_i | input | 3 | Trigger condition select (0..7, see R3 to R6) |
| exec_qual_i | input | 1 | 1: execute qualification, 0: memory-access qualification |
| halt_en_i | input | 1 | Request a halt when the trigger fires |
| addr_a_i | input | AW | Comparator A address (lower window bound) |
| addr_b_i | input | AW | Comparator B address (upper window bound) |
| data_cmp_i | input | DW | Data compare value for modes 5 and 6 |
| bus_valid_i | input | 1 | Bus cycle strobe |
| bus_fetch_i | input | 1 | Current bus cycle is an instruction fetch |
| bus_addr_i | input | AW | Bus address |
| bus_data_i | input | DW | Bus data (read or write value, or opcode) |
| trigger_o | output | 1 | One-cycle trigger pulse |
| hit_o | output | 1 | Sticky trigger-hit flag |
| halt_req_o | output | 1 | Sticky halt request |

## Verification
With access qualification the trigger, hit flag and halt request all change one clock after the bus cycle that satisfies the condition. With execute qualification they change TRACK_DEPTH+1 clocks after it. An arm pulse clears them one clock after it is presented. The bench keeps a behavioural model that updates on each rising edge from the inputs it has just driven, and holds fetch events in a queue that is exactly TRACK_DEPTH long. It compares all three outputs against the model at every falling edge, so each delay is checked in the cycle where the change is due, and also in the cycles before and after it.

// File: rtl/bus_trigger_pkg.sv
package bus_trigger_pkg;

  typedef enum logic [2:0] {
    MODE_A        = 3'd0,
    MODE_A_OR_B   = 3'd1,
    MODE_INSIDE   = 3'd2,
    MODE_OUTSIDE  = 3'd3,
    MODE_A_THEN_B = 3'd4,
    MODE_DATA_EQ  = 3'd5,
    MODE_DATA_NE  = 3'd6,
    MODE_OFF      = 3'd7
  } trig_mode_e;

  // One qualified bus cycle as seen by the condition logic
  typedef struct packed {
    logic valid;
    logic hit_a;
    logic hit_b;
    logic below_a;
    logic above_b;
    logic data_eq;
  } bus_event_t;

endpackage

// File: rtl/addr_match.sv
module addr_match #(
  parameter int AW    = 16,
  parameter bit UPPER = 1'b0
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] ref_i,
  output logic          eq_o,
  output logic          beyond_o
);

  assign eq_o = (addr_i == ref_i);

  // The lower bound flags addresses below it; the upper bound flags addresses above it
  generate
    if (UPPER) begin : g_upper
      assign beyond_o = (addr_i > ref_i);
    end else begin : g_lower
      assign beyond_o = (addr_i < ref_i);
    end
  endgenerate

endmodule

// File: rtl/event_delay.sv
module event_delay
  import bus_trigger_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush_i,
  input  bus_event_t ev_i,
  output bus_event_t ev_o
);

  bus_event_t stg_q [DEPTH];
  bus_event_t stg_d [DEPTH];

  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      if (s == 0) begin : g_head
        always_comb stg_d[s] = flush_i ? '0 : ev_i;
      end else begin : g_body
        always_comb stg_d[s] = flush_i ? '0 : stg_q[s-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_d[s];
      end
    end
  endgenerate

  assign ev_o = stg_q[DEPTH-1];

endmodule

// File: rtl/trig_cond_fsm.sv
module trig_cond_fsm
  import bus_trigger_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm_i,
  input  logic [2:0] mode_i,
  input  logic       halt_en_i,
  input  bus_event_t ev_i,
  output logic       trigger_o,
  output logic       hit_o,
  output logic       halt_req_o
);

  logic armed_q, seen_a_q, trig_q, hit_q, halt_q;
  logic armed_d, seen_a_d, trig_d, hit_d, halt_d;
  logic cond, fire, upd_en;
  trig_mode_e mode;

  assign mode = trig_mode_e'(mode_i);

  always_comb begin
    unique case (mode)
      MODE_A:        cond = ev_i.hit_a;
      MODE_A_OR_B:   cond = ev_i.hit_a | ev_i.hit_b;
      MODE_INSIDE:   cond = ~ev_i.below_a & ~ev_i.above_b;
      MODE_OUTSIDE:  cond = ev_i.below_a | ev_i.above_b;
      MODE_A_THEN_B: cond = ev_i.hit_b & seen_a_q;
      MODE_DATA_EQ:  cond = ev_i.hit_a & ev_i.data_eq;
      MODE_DATA_NE:  cond = ev_i.hit_a & ~ev_i.data_eq;
      default:       cond = 1'b0;
    endcase
  end

  assign fire = armed_q & ev_i.valid & cond;

  always_comb begin
    if (arm_i) begin
      armed_d  = 1'b1;
      seen_a_d = 1'b0;
      trig_d   = 1'b0;
      hit_d    = 1'b0;
      halt_d   = 1'b0;
    end else begin
      armed_d  = armed_q & ~fire;
      seen_a_d = seen_a_q | (armed_q & ev_i.valid & ev_i.hit_a);
      trig_d   = fire;
      hit_d    = hit_q | fire;
      halt_d   = halt_q | (fire & halt_en_i);
    end
  end

  // State only moves on arm, on an event, or to end a pulse
  assign upd_en = arm_i | ev_i.valid | trig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      seen_a_q <= 1'b0;
      trig_q   <= 1'b0;
      hit_q    <= 1'b0;
      halt_q   <= 1'b0;
    end else if (upd_en) begin
      armed_q  <= armed_d;
      seen_a_q <= seen_a_d;
      trig_q   <= trig_d;
      hit_q    <= hit_d;
      halt_q   <= halt_d;
    end
  end

  assign trigger_o  = trig_q;
  assign hit_o      = hit_q;
  assign halt_req_o = halt_q;

endmodule

// File: rtl/bus_trigger_unit.sv
module bus_trigger_unit
  import bus_trigger_pkg::*;
#(
  parameter int AW          = 16,
  parameter int DW          = 8,
  parameter int TRACK_DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_i,
  input  logic [2:0]    mode_i,
  input  logic          exec_qual_i,
  input  logic          halt_en_i,
  input  logic [AW-1:0] addr_a_i,
  input  logic [AW-1:0] addr_b_i,
  input  logic [DW-1:0] data_cmp_i,
  input  logic          bus_valid_i,
  input  logic          bus_fetch_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_data_i,
  output logic          trigger_o,
  output logic          hit_o,
  output logic          halt_req_o
);

  localparam int NCMP = 2;

  logic [AW-1:0] cmp_ref [NCMP];
  logic [NCMP-1:0] cmp_eq, cmp_beyond;
  bus_event_t ev_now, ev_dly, ev_eval;

  assign cmp_ref[0] = addr_a_i;
  assign cmp_ref[1] = addr_b_i;

  generate
    for (genvar c = 0; c < NCMP; c++) begin : g_cmp
      addr_match #(.AW(AW), .UPPER(c == 1)) u_match (
        .addr_i   (bus_addr_i),
        .ref_i    (cmp_ref[c]),
        .eq_o     (cmp_eq[c]),
        .beyond_o (cmp_beyond[c])
      );
    end
  endgenerate

  always_comb begin
    ev_now.valid   = bus_valid_i & (bus_fetch_i | ~exec_qual_i);
    ev_now.hit_a   = cmp_eq[0];
    ev_now.hit_b   = cmp_eq[1];
    ev_now.below_a = cmp_beyond[0];
    ev_now.above_b = cmp_beyond[1];
    ev_now.data_eq = (bus_data_i == data_cmp_i);
  end

  event_delay #(.DEPTH(TRACK_DEPTH)) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush_i (arm_i),
    .ev_i    (ev_now),
    .ev_o    (ev_dly)
  );

  assign ev_eval = exec_qual_i ? ev_dly : ev_now;

  trig_cond_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_i      (arm_i),
    .mode_i     (mode_i),
    .halt_en_i  (halt_en_i),
    .ev_i       (ev_eval),
    .trigger_o  (trigger_o),
    .hit_o      (hit_o),
    .halt_req_o (halt_req_o)
  );

endmodule

// File: rtl/bus_trigger_checker.sv
module bus_trigger_checker #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          arm_i,
  input logic [2:0]    mode_i,
  input logic          exec_qual_i,
  input logic          halt_en_i,
  input logic          bus_valid_i,
  input logic [DW-1:0] bus_data_i,
  input logic [DW-1:0] data_cmp_i,
  input logic [AW-1:0] bus_addr_i,
  input logic          trigger_o,
  input logic          hit_o,
  input logic          halt_req_o
);

  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> (!hit_o && !trigger_o && !halt_req_o)); // R2

  AST_ACCESS_NEEDS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (trigger_o && $past(!exec_qual_i) && !$past(arm_i)) |-> $past(bus_valid_i)); // R7

  AST_DATA_EQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (trigger_o && $past(!exec_qual_i) && $past(mode_i) == 3'd5)
      |-> ($past(bus_data_i) == $past(data_cmp_i))); // R6

  AST_MODE_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_i) == 3'd7) |-> !trigger_o); // R6

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    trigger_o |=> !trigger_o); // R9

  AST_PULSE_SETS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    trigger_o |-> hit_o); // R9

  AST_HIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && !arm_i) |=> (hit_o && !trigger_o)); // R9

  AST_HALT_WITH_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req_o |-> hit_o); // R10

  AST_HALT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_req_o) |-> $past(halt_en_i)); // R10

  always_comb begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!trigger_o && !hit_o && !halt_req_o); // R1
    end
  end

endmodule

bind bus_trigger_unit bus_trigger_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .arm_i       (arm_i),
  .mode_i      (mode_i),
  .exec_qual_i (exec_qual_i),
  .halt_en_i   (halt_en_i),
  .bus_valid_i (bus_valid_i),
  .bus_data_i  (bus_data_i),
  .data_cmp_i  (data_cmp_i),
  .bus_addr_i  (bus_addr_i),
  .trigger_o   (trigger_o),
  .hit_o       (hit_o),
  .halt_req_o  (halt_req_o)
);

// File: tb/bus_trigger_unit_tb.sv
module bus_trigger_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int TD = 2;

  logic          clk;
  logic          rst_n;
  logic          arm_i;
  logic [2:0]    mode_i;
  logic          exec_qual_i;
  logic          halt_en_i;
  logic [AW-1:0] addr_a_i, addr_b_i;
  logic [DW-1:0] data_cmp_i;
  logic          bus_valid_i, bus_fetch_i;
  logic [AW-1:0] bus_addr_i;
  logic [DW-1:0] bus_data_i;
  logic          trigger_o, hit_o, halt_req_o;

  bus_trigger_unit #(.AW(AW), .DW(DW), .TRACK_DEPTH(TD)) u_dut (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .mode_i(mode_i),
    .exec_qual_i(exec_qual_i), .halt_en_i(halt_en_i),
    .addr_a_i(addr_a_i), .addr_b_i(addr_b_i), .data_cmp_i(data_cmp_i),
    .bus_valid_i(bus_valid_i), .bus_fetch_i(bus_fetch_i),
    .bus_addr_i(bus_addr_i), .bus_data_i(bus_data_i),
    .trigger_o(trigger_o), .hit_o(hit_o), .halt_req_o(halt_req_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    bit v;
    int unsigned addr;
    int unsigned data;
  } cyc_s;

  cyc_s  pend[$];
  bit    m_armed, m_seen, m_trig, m_hit, m_halt;
  int    vectors, errors, trig_count;
  string cur_req;
  bit    done;

  function automatic bit cond_met(cyc_s c);
    int unsigned a = addr_a_i, b = addr_b_i, k = data_cmp_i;
    case (mode_i)
      3'd0: return c.addr == a;
      3'd1: return c.addr == a || c.addr == b;
      3'd2: return c.addr >= a && c.addr <= b;
      3'd3: return c.addr < a || c.addr > b;
      3'd4: return c.addr == b && m_seen;
      3'd5: return c.addr == a && c.data == k;
      3'd6: return c.addr == a && c.data != k;
      default: return 1'b0;
    endcase
  endfunction

  task automatic model_edge();
    cyc_s now, ev;
    bit fire;
    now.v    = bus_valid_i && (bus_fetch_i || !exec_qual_i);
    now.addr = bus_addr_i;
    now.data = bus_data_i;
    if (!rst_n) begin
      m_armed = 0; m_seen = 0; m_trig = 0; m_hit = 0; m_halt = 0;
      pend.delete();
      for (int i = 0; i < TD; i++) pend.push_back('{0, 0, 0});
      return;
    end
    ev   = exec_qual_i ? pend[0] : now;
    fire = m_armed && ev.v && cond_met(ev);
    if (arm_i) begin
      m_armed = 1; m_seen = 0; m_trig = 0; m_hit = 0; m_halt = 0;
      pend.delete();
      for (int i = 0; i < TD; i++) pend.push_back('{0, 0, 0});
    end else begin
      if (m_armed && ev.v && ev.addr == int'(addr_a_i)) m_seen = 1;
      m_trig = fire;
      if (fire) begin
        m_hit = 1; m_armed = 0;
        if (halt_en_i) m_halt = 1;
      end
      void'(pend.pop_front());
      pend.push_back(now);
    end
  endtask

  task automatic compare();
    vectors++;
    if (trigger_o) trig_count++;
    if ({trigger_o, hit_o, halt_req_o} !== {m_trig, m_hit, m_halt}) begin
      errors++;
      $display("FAIL %s t=%0t trig/hit/halt actual=%b%b%b expected=%b%b%b", cur_req, $time,
               trigger_o, hit_o, halt_req_o, m_trig, m_hit, m_halt);
    end
  endtask

  task automatic cyc(bit arm, bit v, bit f, int unsigned addr, int unsigned data);
    arm_i = arm; bus_valid_i = v; bus_fetch_i = f;
    bus_addr_i = AW'(addr); bus_data_i = DW'(data);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask

  task automatic arm();
    cyc(1, 1, 1, addr_a_i, data_cmp_i); // the event presented with arm is ignored (R2)
  endtask

  task automatic cfg(int m, bit ex, bit he, int unsigned a, int unsigned b, int unsigned k);
    mode_i = 3'(m); exec_qual_i = ex; halt_en_i = he;
    addr_a_i = AW'(a); addr_b_i = AW'(b); data_cmp_i = DW'(k);
  endtask

  task automatic expect_count(string req, int exp_n);
    vectors++;
    if (trig_count != exp_n) begin
      errors++;
      $display("FAIL %s trigger pulses actual=%0d expected=%0d", req, trig_count, exp_n);
    end
    trig_count = 0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    done = 1;
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    vectors = 0; errors = 0; trig_count = 0; done = 0;
    rst_n = 0; cur_req = "R1";
    cfg(0, 0, 0, 'h100, 'h1FF, 'h5A);
    arm_i = 0; bus_valid_i = 0; bus_fetch_i = 0; bus_addr_i = '0; bus_data_i = '0;
    idle(3);
    rst_n = 1;
    // R1: disarmed after reset, A hits do nothing
    cyc(0, 1, 0, 'h100, 0);
    cyc(0, 1, 1, 'h100, 0);
    idle(2);
    expect_count("R1", 0);

    // R3: mode 0
    cur_req = "R3";
    arm(); idle(1);
    cyc(0, 1, 0, 'h0FF, 0);
    cyc(0, 1, 0, 'h101, 0);
    cyc(0, 1, 0, 'h100, 0);
    idle(2);
    expect_count("R3", 1);
    arm(); cyc(0, 1, 0, 'h1FF, 0); idle(2);
    expect_count("R3", 0);
    // R3: mode 1, B first
    cfg(1, 0, 0, 'h100, 'h180, 0);
    arm(); cyc(0, 1, 0, 'h180, 0); idle(1); cyc(0, 1, 0, 'h100, 0); idle(2);
    expect_count("R3", 1);

    // R4: window edges
    cur_req = "R4";
    cfg(2, 0, 0, 'h200, 'h2FF, 0);
    arm(); cyc(0, 1, 0, 'h1FF, 0); cyc(0, 1, 0, 'h300, 0); cyc(0, 1, 0, 'h200, 0); idle(2);
    arm(); cyc(0, 1, 0, 'h2FF, 0); idle(2);
    expect_count("R4", 2);
    cfg(3, 0, 0, 'h200, 'h2FF, 0);
    arm(); cyc(0, 1, 0, 'h250, 0); cyc(0, 1, 0, 'h2FF, 0); cyc(0, 1, 0, 'h300, 0); idle(2);
    arm(); cyc(0, 1, 0, 'h1FF, 0); idle(2);
    expect_count("R4", 2);

    // R5: A then B
    cur_req = "R5";
    cfg(4, 0, 0, 'h300, 'h340, 0);
    arm(); cyc(0, 1, 0, 'h340, 0); cyc(0, 1, 0, 'h300, 0); idle(1); cyc(0, 1, 0, 'h340, 0); idle(2);
    expect_count("R5", 1);
    cfg(4, 0, 0, 'h400, 'h400, 0);
    arm(); cyc(0, 1, 0, 'h400, 0); idle(1);
    expect_count("R5", 0);
    cyc(0, 1, 0, 'h400, 0); idle(2);
    expect_count("R5", 1);

    // R2: arm clears A history
    cur_req = "R2";
    cfg(4, 0, 0, 'h300, 'h340, 0);
    arm(); cyc(0, 1, 0, 'h300, 0); arm(); cyc(0, 1, 0, 'h340, 0); idle(2);
    expect_count("R2", 0);
    cfg(0, 0, 0, 'h100, 'h1FF, 0);
    arm(); idle(2);
    expect_count("R2", 0);

    // R6: data qualified
    cur_req = "R6";
    cfg(5, 0, 0, 'h500, 'h5FF, 'h3C);
    arm(); cyc(0, 1, 0, 'h500, 'h3D); cyc(0, 1, 0, 'h501, 'h3C); cyc(0, 1, 0, 'h500, 'h3C); idle(2);
    expect_count("R6", 1);
    cfg(6, 0, 0, 'h500, 'h5FF, 'h3C);
    arm(); cyc(0, 1, 0, 'h500, 'h3C); cyc(0, 1, 0, 'h500, 'hC3); idle(2);
    expect_count("R6", 1);
    cfg(7, 0, 0, 'h500, 'h5FF, 'h3C);
    arm(); cyc(0, 1, 0, 'h500, 'h3C); cyc(0, 1, 0, 'h000, 0); cyc(0, 1, 0, 'hFFFF, 0); idle(2);
    expect_count("R6", 0);

    // R7: access qualification counts data and fetch cycles
    cur_req = "R7";
    cfg(0, 0, 0, 'h600, 'h6FF, 0);
    arm(); cyc(0, 0, 1, 'h600, 0); cyc(0, 1, 0, 'h600, 0); idle(2);
    arm(); cyc(0, 1, 1, 'h600, 0); idle(2);
    expect_count("R7", 2);

    // R8: execute qualification, fetch only, delayed
    cur_req = "R8";
    cfg(0, 1, 0, 'h700, 'h7FF, 0);
    arm(); cyc(0, 1, 0, 'h700, 0); idle(4);
    expect_count("R8", 0);
    cyc(0, 1, 1, 'h700, 0); idle(5);
    expect_count("R8", 1);
    arm(); cyc(0, 1, 1, 'h700, 0); arm(); idle(5);
    expect_count("R8", 0);

    // R9: one-shot, later matches ignored
    cur_req = "R9";
    cfg(1, 0, 0, 'h800, 'h880, 0);
    arm(); cyc(0, 1, 0, 'h800, 0); cyc(0, 1, 0, 'h880, 0); cyc(0, 1, 0, 'h800, 0); idle(3);
    expect_count("R9", 1);

    // R10: halt request
    cur_req = "R10";
    cfg(0, 0, 1, 'h900, 'h9FF, 0);
    arm(); cyc(0, 1, 0, 'h900, 0); idle(3);
    arm(); idle(1);
    cfg(0, 0, 0, 'h900, 'h9FF, 0);
    cyc(0, 1, 0, 'h900, 0); idle(3);
    expect_count("R10", 2);

    finish_run();
  end

endmodule